// File: doc/BRIEF.md
# Two-Way Page Translation Buffer

This block keeps recently used virtual-to-physical page translations for a core with a 40-bit virtual address, 16 KiB pages and a 36-bit physical address. A lookup presents a virtual address and an access kind. In the same cycle the block reports one of two results. On a hit it gives the physical address, formed from the stored physical page number and the untouched page offset. On a miss the surrounding logic is expected to start a page-table walk.

The walker's result comes back through a refill port and is written into one of the two ways of the set that the virtual page selects. The block places it in a free way when one exists, and otherwise in the way used least recently. Every hit is also checked against the entry's access rights, and a disallowed access raises a fault flag. The block keeps a reference bit and a dirty bit per entry. A single flush input invalidates every entry when the address space changes.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses. When `lk_valid` is low, `lk_hit`, `lk_miss`, `lk_fault`, `lk_ref`, `lk_dirty` and `lk_paddr` are all zero.
- R2: Address bits 13:0 are the page offset, bits 21:14 select one of 256 sets, and bits 39:22 are the 18-bit tag. On a hit in the same cycle, `lk_paddr` = {stored 22-bit page number, offset}.
- R3: A valid lookup with no matching valid entry in its set raises `lk_miss` alone and drives `lk_paddr` to zero. `lk_hit` and `lk_miss` are never both high.
- R4: A refill (`fill_valid`) writes a valid entry with the reference bit clear. The entry is visible to a lookup from the next cycle. The target way is way 0 if it is invalid, else way 1 if it is invalid, else the least recently used way.
- R5: A hit makes the other way of that set least recently used, and so does a refill into a way. A lookup in the same cycle as a refill changes no reference, dirty or recency state.
- R6: A refill whose virtual page is already held in its set overwrites that same way, so a page is never held twice.
- R7: Rights codes are 00 none, 01 read only, 10 read/write and 11 read/execute. Access kinds are 00 load, 01 store, 10 fetch, and 11 behaves as a load. On a hit, `lk_fault` is high when the access is not allowed: any kind under 00, store or fetch under 01, fetch under 10, store under 11.
- R8: `lk_ref` shows the entry's reference bit as it was before the lookup. Each hit (outside a refill cycle) sets the bit.
- R9: `lk_dirty` shows the entry's dirty bit. The bit is loaded from `fill_dirty` and is set by a store hit that does not fault. A faulting store leaves it unchanged.
- R10: `flush` invalidates every entry and resets recency at the next edge. A refill in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 40 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation, walk needed |
| lk_fault | output | 1 | Hit but access not permitted |
| lk_paddr | output | 36 | Physical address on a hit, zero otherwise |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| lk_ref | output | 1 | Reference bit of the hit entry before this lookup |
| fill_valid | input | 1 | Refill request from the walker |
| fill_vpn | input | 26 | Virtual page number being refilled |
| fill_ppn | input | 22 | Physical page number for it |
| fill_rights | input | 2 | Access-rights code for it |
| fill_dirty | input | 1 | Initial dirty bit |

## Verification
The bench builds the block at its package defaults, with 256 sets of two ways. That size is small enough for the bench to sweep every set twice, once per way, with page numbers and offsets computed arithmetically from the set index. One set is then driven through a replacement ordering in which only a correct recency update evicts the right way, followed by an overwrite of a page that is already held. All four rights codes are crossed with all three access kinds, and the reference and dirty bits are followed through a sequence of loads and stores. The flush is checked both alone and when it collides with a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W  = 40;
    localparam int PA_W  = 36;
    localparam int OFF_W = 14;
    localparam int IDX_W = 8;
    localparam int WAYS  = 2;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int SETS  = 1 << IDX_W;

    typedef enum logic [1:0] {
        RIGHT_NONE = 2'b00,
        RIGHT_RO   = 2'b01,
        RIGHT_RW   = 2'b10,
        RIGHT_RX   = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } access_e;

    typedef struct packed {
        logic               valid;
        logic               dirty;
        logic               refd;
        rights_e            rights;
        logic [TAG_W-1:0]   tag;
        logic [PPN_W-1:0]   ppn;
    } entry_t;

    function automatic logic may_access(rights_e r, access_e k);
        logic is_store;
        logic is_fetch;
        is_store = (k == ACC_STORE);
        is_fetch = (k == ACC_FETCH);
        case (r)
            RIGHT_RO: may_access = !is_store && !is_fetch;
            RIGHT_RW: may_access = !is_fetch;
            RIGHT_RX: may_access = !is_store;
            default:  may_access = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_pkg::*;
#(
    parameter int N_SETS = SETS,
    parameter int IW     = IDX_W,
    parameter int TW     = TAG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [IW-1:0] a_idx,
    input  logic [TW-1:0] a_tag,
    output logic          a_hit,
    output entry_t        a_ent,
    input  logic [IW-1:0] b_idx,
    input  logic [TW-1:0] b_tag,
    output logic          b_valid,
    output logic          b_match,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  entry_t        wr_ent,
    input  logic          upd_en,
    input  logic [IW-1:0] upd_idx,
    input  logic          upd_dirty
);

    entry_t mem [N_SETS];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < N_SETS; i++) begin
                mem[i].valid <= 1'b0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_ent;
        end else if (upd_en) begin
            mem[upd_idx].refd <= 1'b1;
            if (upd_dirty) begin
                mem[upd_idx].dirty <= 1'b1;
            end
        end
    end

    always_comb begin
        a_ent   = mem[a_idx];
        a_hit   = a_ent.valid && (a_ent.tag == a_tag);
        b_valid = mem[b_idx].valid;
        b_match = b_valid && (mem[b_idx].tag == b_tag);
    end

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> !a_hit);

    assert_write_visible_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush && wr_ent.valid) |=>
            (!(a_idx == $past(wr_idx) && a_tag == $past(wr_ent.tag)) || a_hit));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int NW    = WAYS,
    localparam int PW   = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic [NW-1:0] way_valid,
    input  logic [NW-1:0] way_match,
    input  logic [PW-1:0] lru_ptr,
    output logic [NW-1:0] sel
);

    always_comb begin
        logic found;
        sel   = '0;
        found = 1'b0;
        for (int w = 0; w < NW; w++) begin
            if (!found && way_match[w]) begin
                sel[w] = 1'b1;
                found  = 1'b1;
            end
        end
        for (int w = 0; w < NW; w++) begin
            if (!found && !way_valid[w]) begin
                sel[w] = 1'b1;
                found  = 1'b1;
            end
        end
        if (!found) begin
            sel[lru_ptr] = 1'b1;
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_kind,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_dirty,
    output logic             lk_ref,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_rights,
    input  logic             fill_dirty
);

    logic [IDX_W-1:0] a_idx;
    logic [TAG_W-1:0] a_tag;
    logic [IDX_W-1:0] f_idx;
    logic [TAG_W-1:0] f_tag;

    assign a_idx = lk_vaddr[OFF_W +: IDX_W];
    assign a_tag = lk_vaddr[VA_W-1 -: TAG_W];
    assign f_idx = fill_vpn[IDX_W-1:0];
    assign f_tag = fill_vpn[VPN_W-1 -: TAG_W];

    logic [WAYS-1:0] way_hit;
    logic [WAYS-1:0] way_fvalid;
    logic [WAYS-1:0] way_fmatch;
    logic [WAYS-1:0] way_wr;
    logic [WAYS-1:0] way_upd;
    logic [WAYS-1:0] victim_sel;
    entry_t          way_ent [WAYS];
    entry_t          fill_ent;
    entry_t          sel_ent;
    logic            hit_any;
    logic            permitted;
    logic            touch;
    logic            upd_dirty;
    logic [SETS-1:0] lru_q;

    assign fill_ent = '{valid:  1'b1,
                        dirty:  fill_dirty,
                        refd:   1'b0,
                        rights: rights_e'(fill_rights),
                        tag:    f_tag,
                        ppn:    fill_ppn};

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way #(.N_SETS(SETS), .IW(IDX_W), .TW(TAG_W)) u_way (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .a_idx     (a_idx),
            .a_tag     (a_tag),
            .a_hit     (way_hit[w]),
            .a_ent     (way_ent[w]),
            .b_idx     (f_idx),
            .b_tag     (f_tag),
            .b_valid   (way_fvalid[w]),
            .b_match   (way_fmatch[w]),
            .wr_en     (way_wr[w]),
            .wr_idx    (f_idx),
            .wr_ent    (fill_ent),
            .upd_en    (way_upd[w]),
            .upd_idx   (a_idx),
            .upd_dirty (upd_dirty)
        );
    end

    tlb_victim #(.NW(WAYS)) u_victim (
        .way_valid (way_fvalid),
        .way_match (way_fmatch),
        .lru_ptr   (lru_q[f_idx]),
        .sel       (victim_sel)
    );

    always_comb begin
        hit_any = |way_hit;
        sel_ent = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                sel_ent = way_ent[w];
            end
        end
        permitted = may_access(sel_ent.rights, access_e'(lk_kind));
        lk_hit    = lk_valid && hit_any;
        lk_miss   = lk_valid && !hit_any;
        lk_fault  = lk_hit && !permitted;
        lk_paddr  = lk_hit ? {sel_ent.ppn, lk_vaddr[OFF_W-1:0]} : '0;
        lk_dirty  = lk_hit && sel_ent.dirty;
        lk_ref    = lk_hit && sel_ent.refd;
        touch     = lk_hit && !fill_valid && !flush;
        upd_dirty = (access_e'(lk_kind) == ACC_STORE) && permitted;
        way_upd   = touch ? way_hit : '0;
        way_wr    = (fill_valid && !flush) ? victim_sel : '0;
    end

    // one recency bit per set: names the way to evict next
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            lru_q <= '0;
        end else if (fill_valid) begin
            lru_q[f_idx] <= victim_sel[0];
        end else if (touch) begin
            lru_q[a_idx] <= way_hit[0];
        end
    end

    assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss));

    assert_single_way_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(way_hit) <= 1);

    assert_fault_needs_hit_R7: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> lk_hit);

    assert_victim_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> ($countones(victim_sel) == 1));

    assert_ref_after_hit_R8: assert property (@(posedge clk) disable iff (rst)
        (touch && !rst) |=>
            (!(lk_hit && lk_vaddr[VA_W-1:OFF_W] == $past(lk_vaddr[VA_W-1:OFF_W])) || lk_ref));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault || lk_ref || lk_dirty));

endmodule

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        lk_valid;
    logic [39:0] lk_vaddr;
    logic [1:0]  lk_kind;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty, lk_ref;
    logic [35:0] lk_paddr;
    logic        fill_valid;
    logic [25:0] fill_vpn;
    logic [21:0] fill_ppn;
    logic [1:0]  fill_rights;
    logic        fill_dirty;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tlb_xlate i_tlb_xlate (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_paddr(lk_paddr), .lk_dirty(lk_dirty), .lk_ref(lk_ref),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_rights(fill_rights), .fill_dirty(fill_dirty)
    );

    function automatic logic [17:0] tag_of(int k, int idx);
        return 18'((k * 4099 + idx * 3) & 32'h3FFFF);
    endfunction

    function automatic logic [21:0] ppn_of(int k, int idx, int gen);
        return 22'((idx * 13 + k * 977 + gen * 50021) & 32'h3FFFFF);
    endfunction

    function automatic logic [13:0] off_of(int k, int idx);
        return 14'((idx * 37 + k * 11) & 32'h3FFF);
    endfunction

    function automatic logic [39:0] va_of(int k, int idx);
        return {tag_of(k, idx), 8'(idx), off_of(k, idx)};
    endfunction

    function automatic logic [35:0] pa_of(int k, int idx, int gen);
        return {ppn_of(k, idx, gen), off_of(k, idx)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int k, input int idx, input int gen,
                        input logic [1:0] r, input logic d, input logic fl);
        @(negedge clk);
        lk_valid    = 1'b0;
        fill_valid  = 1'b1;
        fill_vpn    = {tag_of(k, idx), 8'(idx)};
        fill_ppn    = ppn_of(k, idx, gen);
        fill_rights = r;
        fill_dirty  = d;
        flush       = fl;
        @(negedge clk);
        fill_valid  = 1'b0;
        flush       = 1'b0;
    endtask

    // drive one lookup, sample after the combinational path settles
    task automatic look(input int k, input int idx, input logic [1:0] kind,
                        input bit exp_hit, input int gen, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va_of(k, idx);
        lk_kind  = kind;
        #1;
        chk(lk_hit == exp_hit, req, "hit", 64'(lk_hit), 64'(exp_hit));
        chk(lk_miss == !exp_hit, req, "miss", 64'(lk_miss), 64'(!exp_hit));
        if (exp_hit)
            chk(lk_paddr == pa_of(k, idx, gen), req, "paddr", 64'(lk_paddr), 64'(pa_of(k, idx, gen)));
        else
            chk(lk_paddr == '0, req, "paddr", 64'(lk_paddr), 64'd0);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // lookup checking fault, reference and dirty outputs
    task automatic look_bits(input int k, input int idx, input logic [1:0] kind,
                             input bit e_fault, input bit e_ref, input bit e_dirty,
                             input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va_of(k, idx);
        lk_kind  = kind;
        #1;
        chk(lk_hit == 1'b1, req, "hit", 64'(lk_hit), 64'd1);
        chk(lk_fault == e_fault, req, "fault", 64'(lk_fault), 64'(e_fault));
        chk(lk_ref == e_ref, req, "ref", 64'(lk_ref), 64'(e_ref));
        chk(lk_dirty == e_dirty, req, "dirty", 64'(lk_dirty), 64'(e_dirty));
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired before the sequence ended");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; flush = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_kind = 2'b00;
        fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_rights = 2'b00; fill_dirty = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: idle outputs quiet, every set empty after reset
        #1;
        chk(!(lk_hit || lk_miss || lk_fault || lk_ref || lk_dirty) && lk_paddr == '0,
            "R1", "idle outputs", 64'({lk_hit, lk_miss, lk_fault, lk_ref, lk_dirty}), 64'd0);
        for (int i = 0; i < 256; i += 51) look(1, i, 2'b00, 1'b0, 0, "R1");

        // R2 R4: first way of every set
        for (int i = 0; i < 256; i++) fill(1, i, 0, 2'b10, 1'b0, 1'b0);
        for (int i = 0; i < 256; i++) look(1, i, 2'b00, 1'b1, 0, "R2");

        // R4: second way of every set, both pages resident
        for (int i = 0; i < 256; i++) fill(2, i, 0, 2'b10, 1'b0, 1'b0);
        for (int i = 0; i < 256; i++) begin
            look(1, i, 2'b00, 1'b1, 0, "R4");
            look(2, i, 2'b00, 1'b1, 0, "R4");
        end

        // R5: in set 5, a hit on page 1 makes page 2 the victim
        look(1, 5, 2'b00, 1'b1, 0, "R5");
        fill(3, 5, 0, 2'b10, 1'b0, 1'b0);
        look(2, 5, 2'b00, 1'b0, 0, "R5");
        look(3, 5, 2'b00, 1'b1, 0, "R5");
        look(1, 5, 2'b00, 1'b1, 0, "R5");

        // R6: page 1 is most recent, page 3 is the recency victim; refill of page 1 must overwrite its own way
        fill(1, 5, 9, 2'b10, 1'b0, 1'b0);
        look(1, 5, 2'b00, 1'b1, 9, "R6");
        look(3, 5, 2'b00, 1'b1, 0, "R6");

        // R3: unknown page in a full set misses
        look(7, 77, 2'b00, 1'b0, 0, "R3");

        // R10: flush empties every set
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int i = 0; i < 256; i++) look(1, i, 2'b00, 1'b0, 0, "R10");
        look(3, 5, 2'b00, 1'b0, 0, "R10");

        // R10: refill colliding with flush is dropped
        fill(6, 60, 0, 2'b10, 1'b0, 1'b1);
        look(6, 60, 2'b00, 1'b0, 0, "R10");

        // R7: every rights code against load, store, fetch
        for (int r = 0; r < 4; r++) begin
            fill(4, 20 + r, 0, 2'(r), 1'b0, 1'b0);
            for (int kd = 0; kd < 3; kd++) begin
                bit e;
                e = (r == 0) || (kd == 1 && r != 2) || (kd == 2 && r != 3);
                @(negedge clk);
                lk_valid = 1'b1; lk_vaddr = va_of(4, 20 + r); lk_kind = 2'(kd);
                #1;
                chk(lk_hit && lk_fault == e, "R7", $sformatf("rights=%0d kind=%0d fault", r, kd),
                    64'({lk_hit, lk_fault}), 64'({1'b1, e}));
                @(negedge clk); lk_valid = 1'b0;
            end
        end
        // R7: kind 11 behaves as a load under read-only
        fill(4, 30, 0, 2'b01, 1'b0, 1'b0);
        look_bits(4, 30, 2'b11, 1'b0, 1'b0, 1'b0, "R7");

        // R8 R9: reference and dirty tracking
        fill(5, 40, 0, 2'b10, 1'b0, 1'b0);
        look_bits(5, 40, 2'b00, 1'b0, 1'b0, 1'b0, "R8");
        look_bits(5, 40, 2'b00, 1'b0, 1'b1, 1'b0, "R8");
        look_bits(5, 40, 2'b01, 1'b0, 1'b1, 1'b0, "R9");
        look_bits(5, 40, 2'b00, 1'b0, 1'b1, 1'b1, "R9");
        fill(5, 41, 0, 2'b01, 1'b0, 1'b0);
        look_bits(5, 41, 2'b01, 1'b1, 1'b0, 1'b0, "R9");
        look_bits(5, 41, 2'b00, 1'b0, 1'b1, 1'b0, "R9");
        fill(5, 42, 0, 2'b10, 1'b1, 1'b0);
        look_bits(5, 42, 2'b00, 1'b0, 1'b0, 1'b1, "R9");

        // R8: a refill clears the reference bit again
        fill(5, 40, 0, 2'b10, 1'b0, 1'b0);
        look_bits(5, 40, 2'b00, 1'b0, 1'b0, 1'b0, "R8");

        // R5: lookup during a refill leaves reference bit untouched
        fill(5, 43, 0, 2'b10, 1'b0, 1'b0);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va_of(5, 43); lk_kind = 2'b00;
        fill_valid = 1'b1; fill_vpn = {tag_of(5, 44), 8'd44}; fill_ppn = ppn_of(5, 44, 0);
        fill_rights = 2'b10; fill_dirty = 1'b0;
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0;
        look_bits(5, 43, 2'b00, 1'b0, 1'b0, 1'b0, "R5");

        summary();
        $finish;
    end

endmodule